// File: doc/BRIEF.md
# Selectable-Rate Half-Band Decimator

This block lowers the sample rate of a signed 16-bit stream by 1, 2, 4 or 8. It does this with up to three half-band FIR stages connected in series. Each stage low-pass filters its input and keeps one result for every two samples it accepts. A 2-bit mode input sets how many stages the stream passes through:

| Mode | Decimation | Path |
|------|------------|------|
| 00 | 1× | bypass |
| 01 | 2× | stage one |
| 10 | 4× | stages one and two |
| 11 | 8× | all three stages |

Each sample enters with a valid strobe. Results leave on a registered output with their own valid strobe.

The three stages have 23, 43 and 107 taps. Each stage's coefficients are fixed integers, symmetric about the centre tap, and every tap an even distance from the centre (other than the centre itself) is zero. A stage therefore adds each mirrored pair of samples before it multiplies. It multiplies only the nonzero pairs and the centre tap, and it keeps the full-precision sum. That sum is then divided by the stage's coefficient total, rounded and clamped back to 16 bits before it reaches the next stage.

A change of mode empties every stage. The output stays silent until the newly selected path has refilled.

Top module: `hbd_chain`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0.
- R2: In mode 00, each sample accepted with `in_valid` high appears on `out_data` with `out_valid` high on the next clock edge.
- R3: In mode 01, the output is stage one alone. Stage one is a symmetric 23-tap filter whose nonzero taps, from the outermost inward, are −1, 13, −66, 224, −642 and 2496 (taps 0, 2, …, 10, mirrored), with centre tap 11 equal to 4048.
- R4: In mode 10, stage one feeds stage two. Stage two is a symmetric 43-tap filter whose outer nonzero taps (0, 2, …, 20) are 3, −12, 35, −83, 172, −324, 572, −976, 1680, −3204 and 10274, with centre tap 21 equal to 16274.
- R5: In mode 11, stage two also feeds stage three. Stage three is a symmetric 107-tap filter whose outer nonzero taps (0, 2, …, 52) are −1, 2, −2, 3, −3, 1, 3, −12, 27, −50, 85, −135, 204, −297, 420, −579, 784, −1044, 1376, −1797, 2344, −3072, 4089, −5624, 8280, −14268 and 43520, with centre tap 53 equal to 68508.
- R6: A stage divides its full-precision sum by its coefficient total, which is 8096, 32548 or 137016 for stages one, two and three. It rounds to the nearest integer, and an exact half rounds away from zero.
- R7: A rounded stage result above 32767 becomes 32767, and one below −32768 becomes −32768.
- R8: When `mode` changes, `out_valid` is low on the following edge and every stage is emptied. Later outputs depend only on samples accepted after the change.
- R9: An N-tap stage gives its first result on its N-th accepted sample, then one result on every second accepted sample after that. A stage never gives results on two consecutive cycles.
- R10: Cycles with `in_valid` low change nothing. A stage result appears two cycles after the accepted sample that triggers it.
- R11: A constant input, including full-scale 32767 or −32768, produces that same constant at the output in every mode once the path has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Rate select: 00 bypass, 01 by 2, 10 by 4, 11 by 8 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed output sample |

## Verification
The hardest condition to reach is the third stage's output. It appears only after more than 520 input samples, and only if the two earlier stages have kept the correct phase the whole time, including through idle cycles. The bench feeds long pseudo-random and constant streams in the divide-by-8 mode, with regular gaps in `in_valid`. A scoreboard compares every output against a cascade of direct-form models. Exact ties and clamping are reached by hand-built inputs: a lone ±1 sample that meets the first stage's centre tap, and a full-scale pattern matched to the signs of that stage's coefficients.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  localparam int SMP_W = 16;
  localparam int NSTG  = 3;

  // Outer nonzero taps of each stage, outermost first; mirrored about the centre.
  localparam int K1 [6]  = '{-1, 13, -66, 224, -642, 2496};
  localparam int K2 [11] = '{3, -12, 35, -83, 172, -324, 572, -976, 1680, -3204, 10274};
  localparam int K3 [27] = '{-1, 2, -2, 3, -3, 1, 3, -12, 27, -50, 85, -135, 204, -297,
                             420, -579, 784, -1044, 1376, -1797, 2344, -3072, 4089,
                             -5624, 8280, -14268, 43520};

  function automatic int hb_npair(input int stg);
    case (stg)
      1:       return 6;
      2:       return 11;
      default: return 27;
    endcase
  endfunction

  function automatic int hb_coef(input int stg, input int j);
    case (stg)
      1:       return K1[j];
      2:       return K2[j];
      default: return K3[j];
    endcase
  endfunction

  function automatic int hb_centre(input int stg);
    case (stg)
      1:       return 4048;
      2:       return 16274;
      default: return 68508;
    endcase
  endfunction

  function automatic longint hb_gain(input int stg);
    longint s;
    s = longint'(hb_centre(stg));
    for (int j = 0; j < hb_npair(stg); j++) s += 2 * longint'(hb_coef(stg, j));
    return s;
  endfunction

endpackage

// File: rtl/hbd_rndsat.sv
module hbd_rndsat #(
  parameter int     ACCW = 48,
  parameter int     DW   = 16,
  parameter longint DIV  = 8096
) (
  input  logic signed [ACCW-1:0] acc,
  output logic signed [DW-1:0]   res
);

  localparam logic signed [ACCW-1:0] DIVV = ACCW'(DIV);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(DIV / 2);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - ACCW'(1);

  logic signed [ACCW-1:0] mag, q, sq;

  always_comb begin
    mag = acc[ACCW-1] ? -acc : acc;
    q   = (mag + HALF) / DIVV;
    sq  = acc[ACCW-1] ? -q : q;
    if (sq > MAXV)      res = MAXV[DW-1:0];
    else if (sq < MINV) res = MINV[DW-1:0];
    else                res = sq[DW-1:0];
  end

  // R6
  always_comb begin
    if (!$isunknown(acc)) begin
      sign_keep_chk: assert (!(acc > 0 && res < 0) && !(acc < 0 && res > 0));
    end
  end

endmodule

// File: rtl/hbd_stage.sv
module hbd_stage #(
  parameter int STG  = 1,
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int ACCW = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_dat,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_dat
);

  localparam int     NP   = hbd_pkg::hb_npair(STG);
  localparam int     NTAP = 4 * NP - 1;
  localparam int     CTRI = 2 * NP - 1;
  localparam int     FW   = $clog2(NTAP + 1);
  localparam longint GAIN = hbd_pkg::hb_gain(STG);
  localparam logic [FW-1:0] LASTF = FW'(NTAP - 1);
  localparam logic [FW-1:0] FULLF = FW'(NTAP);
  localparam logic signed [CW-1:0] CCTR = CW'(hbd_pkg::hb_centre(STG));

  logic signed [DW-1:0]   dl   [NTAP];
  logic signed [ACCW-1:0] prod [NP];
  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0]   rs;
  logic [FW-1:0]          fcnt;
  logic                   skip, fire;

  // delay line, newest sample at index 0
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NTAP; i++) dl[i] <= '0;
    end else if (in_vld) begin
      dl[0] <= in_dat;
      for (int i = 1; i < NTAP; i++) dl[i] <= dl[i-1];
    end
  end

  // one multiplier per mirrored nonzero pair
  for (genvar j = 0; j < NP; j++) begin : g_pair
    localparam logic signed [CW-1:0] CJ = CW'(hbd_pkg::hb_coef(STG, j));
    logic signed [DW:0] pre;
    assign pre = {dl[2*j][DW-1], dl[2*j]} + {dl[NTAP-1-2*j][DW-1], dl[NTAP-1-2*j]};
    assign prod[j] = ACCW'(pre) * ACCW'(CJ);
  end

  always_comb begin
    acc = ACCW'(dl[CTRI]) * ACCW'(CCTR);
    for (int j = 0; j < NP; j++) acc = acc + prod[j];
  end

  hbd_rndsat #(.ACCW(ACCW), .DW(DW), .DIV(GAIN)) u_rs (
    .acc (acc),
    .res (rs)
  );

  // fill counter and keep-every-second phase
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fcnt    <= '0;
      skip    <= 1'b0;
      fire    <= 1'b0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      fire    <= 1'b0;
      out_vld <= fire;
      if (fire) out_dat <= rs;
      if (in_vld) begin
        if (fcnt < LASTF) begin
          fcnt <= fcnt + 1'b1;
        end else if (fcnt == LASTF) begin
          fcnt <= FULLF;
          fire <= 1'b1;
          skip <= 1'b1;
        end else begin
          fire <= !skip;
          skip <= !skip;
        end
      end
    end
  end

  // R9
  no_back2back_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R10
  from_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld, 2));

endmodule

// File: rtl/hbd_chain.sv
module hbd_chain (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               in_valid,
  input  logic signed [15:0] in_data,
  output logic               out_valid,
  output logic signed [15:0] out_data
);

  localparam int DW   = hbd_pkg::SMP_W;
  localparam int NSTG = hbd_pkg::NSTG;

  logic [1:0]           mode_q;
  logic                 clr;
  logic                 v [0:NSTG];
  logic signed [DW-1:0] d [0:NSTG];

  always_ff @(posedge clk) begin
    mode_q <= mode;
  end

  assign clr  = (mode != mode_q);
  assign v[0] = in_valid;
  assign d[0] = in_data;

  for (genvar s = 1; s <= NSTG; s++) begin : g_stg
    logic en;
    assign en = v[s-1] && (int'(mode_q) >= s);
    hbd_stage #(.STG(s), .DW(DW)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .in_vld  (en),
      .in_dat  (d[s-1]),
      .out_vld (v[s]),
      .out_dat (d[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= v[mode_q];
      if (v[mode_q]) out_data <= d[mode_q];
    end
  end

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |=> !out_valid);

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && $stable(mode) && in_valid) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/hbd_chain_tb.sv
module hbd_chain_tb;

  typedef int iq_t[$];
  typedef int ia_t[];

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         mode = 2'b00;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  always #2 clk = ~clk;

  hbd_chain u_dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int ntot = 0, nfail = 0, got = 0;
  bit done = 0;
  string cur_tag = "R1";
  iq_t expq;
  int unsigned lf = 32'h1d2c_3b4a;

  int t1 [6]  = '{-1, 13, -66, 224, -642, 2496};
  int t2 [11] = '{3, -12, 35, -83, 172, -324, 572, -976, 1680, -3204, 10274};
  int t3 [27] = '{-1, 2, -2, 3, -3, 1, 3, -12, 27, -50, 85, -135, 204, -297, 420, -579,
                  784, -1044, 1376, -1797, 2344, -3072, 4089, -5624, 8280, -14268, 43520};
  ia_t h1, h2, h3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_sat(input longint acc, input longint g);
    longint q;
    if (acc >= 0) q = (acc + g / 2) / g;
    else          q = -((-acc + g / 2) / g);
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  function automatic iq_t stage_model(input iq_t x, input ia_t h);
    iq_t y;
    longint g = 0;
    int n = h.size();
    foreach (h[i]) g += h[i];
    for (int k = n; k <= x.size(); k += 2) begin
      longint acc = 0;
      for (int i = 0; i < n; i++) acc += longint'(h[i]) * longint'(x[k-1-i]);
      y.push_back(rnd_sat(acc, g));
    end
    return y;
  endfunction

  function automatic iq_t path_model(input int m, input iq_t x);
    iq_t q = x;
    if (m >= 1) q = stage_model(q, h1);
    if (m >= 2) q = stage_model(q, h2);
    if (m >= 3) q = stage_model(q, h3);
    return q;
  endfunction

  function automatic int nxt();
    lf = (lf << 1) ^ (lf[31] ? 32'h04c1_1db7 : 32'h0);
    return int'($signed(lf[31:16]));
  endfunction

  // empties every stage by two mode changes, ends in mode m
  task automatic select_mode(input int m);
    @(negedge clk) in_valid = 1'b0; mode = 2'(m ^ 1);
    @(negedge clk) mode = 2'(m);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_phase(input int m, input string tag, input iq_t x, input bit gaps,
                           input bit fresh);
    iq_t e;
    if (fresh) select_mode(m);
    e = path_model(m, x);
    foreach (e[i]) expq.push_back(e[i]);
    cur_tag = tag;
    got = 0;
    foreach (x[i]) begin
      @(negedge clk) in_valid = 1'b1; in_data = 16'(x[i]);
      if (gaps && (i % 3 == 2)) @(negedge clk) in_valid = 1'b0;
    end
    @(negedge clk) in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(expq.size() == 0 && got == e.size(), {tag, " R9 output count"}, got, e.size());
    expq.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    int e;
    if (!rst && out_valid) begin
      got++;
      if (expq.size() == 0) begin
        chk(1'b0, {cur_tag, " unexpected output"}, int'(out_data), 0);
      end else begin
        e = expq.pop_front();
        chk(int'(out_data) == e, cur_tag, int'(out_data), e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    iq_t x;
    h1 = new[23]; h2 = new[43]; h3 = new[107];
    foreach (h1[i]) h1[i] = 0;
    foreach (h2[i]) h2[i] = 0;
    foreach (h3[i]) h3[i] = 0;
    for (int j = 0; j < 6; j++)  begin h1[2*j] = t1[j]; h1[22-2*j]  = t1[j]; end
    for (int j = 0; j < 11; j++) begin h2[2*j] = t2[j]; h2[42-2*j]  = t2[j]; end
    for (int j = 0; j < 27; j++) begin h3[2*j] = t3[j]; h3[106-2*j] = t3[j]; end
    h1[11] = 4048; h2[21] = 16274; h3[53] = 68508;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_data == 16'sd0, "R1 out_data after reset", int'(out_data), 0);

    // R2 bypass with gaps
    x.delete();
    for (int i = 0; i < 40; i++) x.push_back(i * 1637 - 32000);
    run_phase(0, "R2 bypass", x, 1'b1, 1'b0);

    // R3 stage one, back-to-back input
    x.delete();
    for (int i = 0; i < 120; i++) x.push_back(nxt());
    run_phase(1, "R3 stage one", x, 1'b0, 1'b1);

    // R10 stage one with idle cycles
    x.delete();
    for (int i = 0; i < 90; i++) x.push_back(nxt());
    run_phase(1, "R10 gaps", x, 1'b1, 1'b1);

    // R6 ties: +1 meets centre tap (4048/8096 -> 1), -1 later -> -1
    x.delete();
    for (int i = 0; i < 60; i++) x.push_back(0);
    x[11] = 1; x[41] = -1;
    run_phase(1, "R6 rounding", x, 1'b0, 1'b1);

    // R7 clamp high and low
    x.delete();
    for (int i = 0; i < 23; i++) x.push_back(h1[i] > 0 ? 32767 : (h1[i] < 0 ? -32768 : 0));
    run_phase(1, "R7 clamp high", x, 1'b0, 1'b1);
    x.delete();
    for (int i = 0; i < 23; i++) x.push_back(h1[i] > 0 ? -32768 : (h1[i] < 0 ? 32767 : 0));
    run_phase(1, "R7 clamp low", x, 1'b0, 1'b1);

    // R8: fill with a constant, then change mode; only fresh samples count
    x.delete();
    for (int i = 0; i < 30; i++) x.push_back(20000);
    run_phase(1, "R8 prefill", x, 1'b0, 1'b1);
    x.delete();
    for (int i = 0; i < 50; i++) x.push_back(nxt() / 4);
    run_phase(1, "R8 after change", x, 1'b0, 1'b1);

    // R4 two stages
    x.delete();
    for (int i = 0; i < 300; i++) x.push_back(nxt());
    run_phase(2, "R4 two stages", x, 1'b0, 1'b1);

    // R5 three stages with gaps
    x.delete();
    for (int i = 0; i < 800; i++) x.push_back(nxt());
    run_phase(3, "R5 three stages", x, 1'b1, 1'b1);

    // R11 full-scale constants
    x.delete();
    for (int i = 0; i < 640; i++) x.push_back(32767);
    run_phase(3, "R11 dc high", x, 1'b0, 1'b1);
    x.delete();
    for (int i = 0; i < 200; i++) x.push_back(-32768);
    run_phase(2, "R11 dc low", x, 1'b0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

endmodule